// File: doc/BRIEF.md
# Process-tagged fully associative translation buffer

This block holds a set of address translations for an embedded core. Every entry carries a virtual page number, a page-size code of its own, a process tag, and a real page number with access attributes. Software loads and inspects each entry through a register-style port as two 32-bit words: an upper word with the page number, size code, valid and little-endian bits, and a lower word with the real page number, execute and write grants and eight attribute bits. Read permission is implied for every entry and needs no bit.

A search strobe compares one address against all entries in parallel, using the current process tag. The lowest-numbered matching entry wins, and its index is registered together with a hit flag. A process-tag register sets which address space searches use and which tag new entries take. When that register changes value, a sticky flag asks the surrounding logic to discard any cached translations. A single strobe invalidates every entry at once.

Top module: `pid_tlb`

## Requirements
- R1: After reset every entry is invalid, the process tag is 0, the flush flag is 0, read data is 0, and the search outputs show a miss (hit 0, index all ones).
- R2: An upper-word write takes the size code from bits 9:7, valid from bit 6 and little-endian from bit 5. The stored page number is the written word with every bit below the page size cleared, where the page size is 1024 << (2 × code). An upper-word read returns page number | code<<7 | valid<<6 | little-endian<<5.
- R3: A lower-word write stores the real page number from bits 31:10, the execute grant from bit 9, the write grant from bit 8 and the attributes from bits 7:0. A lower-word read returns those bits in the same places.
- R4: Read data appears on the cycle after the read strobe and is held until the next read.
- R5: An upper-word write records the current process tag in the entry. An upper-word read loads the process-tag register with that entry's recorded tag.
- R6: An entry matches a search when it is valid, its tag equals the current tag or is 0, and the search address with the bits below its page size cleared equals its page number.
- R7: When several entries match, the search reports the lowest index.
- R8: The search result (hit flag and index) is registered one cycle after the strobe and held until the next strobe. A miss gives hit 0 and index all ones.
- R9: A process-tag write of a different value sets the flush flag, and so does a tag load by R5 that changes the value. Writing the same value does not set it. An acknowledge clears the flag, and a change in the same cycle wins over the acknowledge.
- R10: Invalidate-all clears the valid bit of every entry in one cycle and leaves the other fields unchanged.
- R11: The write and read index is 6 bits wide, giving 64 entries, and entry 63 works like any other. The sizes span code 0 (1 KB) to code 7 (16 MB), and each page matches exactly its own address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_hi_i | input | 1 | 1 selects the upper word for the write, 0 the lower word |
| wr_idx_i | input | 6 | Entry index for the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Entry read strobe |
| rd_hi_i | input | 1 | 1 selects the upper word for the read, 0 the lower word |
| rd_idx_i | input | 6 | Entry index for the read |
| rd_data_o | output | 32 | Registered read data |
| inv_all_i | input | 1 | Invalidate every entry |
| srch_en_i | input | 1 | Search strobe |
| srch_addr_i | input | 32 | Address to look up |
| srch_hit_o | output | 1 | Registered hit flag |
| srch_idx_o | output | 6 | Registered index of the lowest matching entry, all ones on a miss |
| pid_wr_i | input | 1 | Process-tag write strobe |
| pid_i | input | 8 | New process tag |
| pid_o | output | 8 | Current process tag |
| flush_o | output | 1 | Sticky flag: cached translations need a flush |
| flush_ack_i | input | 1 | Clears the flush flag |

## Verification
Each write, tag change or invalidate takes effect at the clock edge that samples it, so its effect shows in the very next search or read. Read data and search results are due exactly one cycle after their strobe. The new tag and the flush flag can be seen one cycle after a tag write or an upper-word read. The bench drives every strobe on a falling edge for one cycle and samples the outputs on the following falling edge, which is the first point where the registered result is due. Hold behaviour is checked by sampling again several cycles later with no new strobe.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned PID_W     = 8;
  parameter int unsigned SZ_W      = 3;
  parameter int unsigned MIN_SHIFT = 10;   // smallest page: 1 KB

  // upper word field positions (decoded by software)
  localparam int unsigned HI_LE_BIT = 5;
  localparam int unsigned HI_V_BIT  = 6;
  localparam int unsigned HI_SZ_LSB = 7;
  // lower word field positions
  localparam int unsigned RPN_LSB   = MIN_SHIFT;
  localparam int unsigned LO_X_BIT  = RPN_LSB - 1;
  localparam int unsigned LO_W_BIT  = RPN_LSB - 2;
  localparam int unsigned ATTR_W    = RPN_LSB - 2;
  localparam int unsigned RPN_W     = WORD_W - RPN_LSB;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PID_W-1:0]  pid_t;
  typedef logic [SZ_W-1:0]   size_t;

  // keep-mask of the page number: page bytes = 1K << (2*code)
  function automatic word_t page_mask(size_t code);
    word_t one;
    one = word_t'(1) << MIN_SHIFT;
    return ~((one << (2 * int'(code))) - word_t'(1));
  endfunction
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot import tlb_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_hi_i,
  input  logic  wr_lo_i,
  input  word_t wr_data_i,
  input  pid_t  cur_pid_i,
  input  logic  inv_i,
  input  word_t srch_addr_i,
  input  pid_t  srch_pid_i,
  output word_t hi_word_o,
  output word_t lo_word_o,
  output pid_t  pid_o,
  output logic  valid_o,
  output logic  match_o
);
  word_t                epn_q;
  size_t                size_q;
  logic                 valid_q, le_q;
  pid_t                 pid_q;
  logic [RPN_W-1:0]     rpn_q;
  logic                 ex_q, wp_q;
  logic [ATTR_W-1:0]    attr_q;

  size_t wr_size;
  assign wr_size = wr_data_i[HI_SZ_LSB +: SZ_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epn_q   <= '0;
      size_q  <= '0;
      valid_q <= 1'b0;
      le_q    <= 1'b0;
      pid_q   <= '0;
      rpn_q   <= '0;
      ex_q    <= 1'b0;
      wp_q    <= 1'b0;
      attr_q  <= '0;
    end else begin
      if (wr_hi_i) begin
        size_q  <= wr_size;
        epn_q   <= wr_data_i & page_mask(wr_size);
        valid_q <= wr_data_i[HI_V_BIT];
        le_q    <= wr_data_i[HI_LE_BIT];
        pid_q   <= cur_pid_i;
      end
      if (wr_lo_i) begin
        rpn_q  <= wr_data_i[WORD_W-1:RPN_LSB];
        ex_q   <= wr_data_i[LO_X_BIT];
        wp_q   <= wr_data_i[LO_W_BIT];
        attr_q <= wr_data_i[ATTR_W-1:0];
      end
      // invalidate wins over a same-cycle valid write
      if (inv_i) valid_q <= 1'b0;
    end
  end

  logic pid_ok, addr_ok;
  assign pid_ok  = (pid_q == srch_pid_i) || (pid_q == '0);
  assign addr_ok = (srch_addr_i & page_mask(size_q)) == epn_q;
  assign match_o = valid_q && pid_ok && addr_ok;

  assign hi_word_o = epn_q
                   | (word_t'(size_q)  << HI_SZ_LSB)
                   | (word_t'(valid_q) << HI_V_BIT)
                   | (word_t'(le_q)    << HI_LE_BIT);
  assign lo_word_o = {rpn_q, ex_q, wp_q, attr_q};
  assign pid_o     = pid_q;
  assign valid_o   = valid_q;

  p_epn_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epn_q & ~page_mask(size_q)) == '0);

  p_inv_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !valid_q);

  p_pid_captured_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> pid_q == $past(cur_pid_i));
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |req_i;

  logic [N-1:0] below;
  assign below = (N'(1) << idx_o) - N'(1);

  always_comb begin
    if (hit_o) begin
      p_lowest_wins_r7: assert (req_i[idx_o] && ((req_i & below) == '0));
    end
  end
endmodule

// File: rtl/tlb_pid_ctl.sv
module tlb_pid_ctl import tlb_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  pid_t wr_pid_i,
  input  logic ld_i,
  input  pid_t ld_pid_i,
  input  logic ack_i,
  output pid_t pid_o,
  output logic flush_o
);
  pid_t pid_q, pid_d;
  logic flush_q;

  // explicit write has priority over the read-side load
  always_comb begin
    pid_d = pid_q;
    if (ld_i) pid_d = ld_pid_i;
    if (wr_i) pid_d = wr_pid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pid_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      pid_q   <= pid_d;
      flush_q <= (pid_d != pid_q) || (flush_q && !ack_i);
    end
  end

  assign pid_o   = pid_q;
  assign flush_o = flush_q;

  p_change_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pid_q != $past(pid_q)) |-> flush_q);

  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !wr_i && !ld_i) |=> !flush_q);
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb import tlb_pkg::*; #(
  parameter  int unsigned N_ENTRIES = 64,
  localparam int unsigned IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_hi_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              inv_all_i,
  input  logic              srch_en_i,
  input  logic [WORD_W-1:0] srch_addr_i,
  output logic              srch_hit_o,
  output logic [IDX_W-1:0]  srch_idx_o,
  input  logic              pid_wr_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic [PID_W-1:0]  pid_o,
  output logic              flush_o,
  input  logic              flush_ack_i
);
  word_t                hi_words [N_ENTRIES];
  word_t                lo_words [N_ENTRIES];
  pid_t                 slot_pid [N_ENTRIES];
  logic [N_ENTRIES-1:0] valid_vec, match_vec;
  pid_t                 cur_pid;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));
    tlb_slot i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_hi_i     (sel && wr_hi_i),
      .wr_lo_i     (sel && !wr_hi_i),
      .wr_data_i   (wr_data_i),
      .cur_pid_i   (cur_pid),
      .inv_i       (inv_all_i),
      .srch_addr_i (srch_addr_i),
      .srch_pid_i  (cur_pid),
      .hi_word_o   (hi_words[g]),
      .lo_word_o   (lo_words[g]),
      .pid_o       (slot_pid[g]),
      .valid_o     (valid_vec[g]),
      .match_o     (match_vec[g])
    );
  end

  logic             enc_hit;
  logic [IDX_W-1:0] enc_idx;

  tlb_first_hit #(.N(N_ENTRIES), .IDX_W(IDX_W)) i_first_hit (
    .req_i (match_vec),
    .hit_o (enc_hit),
    .idx_o (enc_idx)
  );

  tlb_pid_ctl i_pid_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (pid_wr_i),
    .wr_pid_i (pid_i),
    .ld_i     (rd_en_i && rd_hi_i),
    .ld_pid_i (slot_pid[rd_idx_i]),
    .ack_i    (flush_ack_i),
    .pid_o    (cur_pid),
    .flush_o  (flush_o)
  );
  assign pid_o = cur_pid;

  word_t            rd_q;
  logic             hit_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      hit_q <= 1'b0;
      idx_q <= '1;
    end else begin
      if (rd_en_i)   rd_q <= rd_hi_i ? hi_words[rd_idx_i] : lo_words[rd_idx_i];
      if (srch_en_i) begin
        hit_q <= enc_hit;
        idx_q <= enc_idx;
      end
    end
  end

  assign rd_data_o  = rd_q;
  assign srch_hit_o = hit_q;
  assign srch_idx_o = idx_q;

  p_miss_all_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_hit_o |-> srch_idx_o == '1);

  p_result_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_en_i |=> $stable(srch_idx_o) && $stable(srch_hit_o));

  p_inv_all_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> valid_vec == '0);

  p_hit_is_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_en_i && !wr_en_i && !inv_all_i && !pid_wr_i && !rd_en_i)
      |=> !srch_hit_o || valid_vec[srch_idx_o]);

  p_read_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/test_pid_tlb.sv
module test_pid_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_hi = 0, rd_en = 0, rd_hi = 0;
  logic [5:0]  wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0, srch_addr = '0;
  logic [31:0] rd_data;
  logic        inv_all = 0, srch_en = 0, pid_wr = 0, flush_ack = 0;
  logic [7:0]  pid_in = '0, pid;
  logic        srch_hit, flush;
  logic [5:0]  srch_idx;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pid_tlb i_pid_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_hi_i(wr_hi), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_hi_i(rd_hi), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .inv_all_i(inv_all),
    .srch_en_i(srch_en), .srch_addr_i(srch_addr),
    .srch_hit_o(srch_hit), .srch_idx_o(srch_idx),
    .pid_wr_i(pid_wr), .pid_i(pid_in), .pid_o(pid), .flush_o(flush),
    .flush_ack_i(flush_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_mask(input logic [2:0] code);
    return ~((32'd1024 << (2 * code)) - 32'd1);
  endfunction

  function automatic logic [31:0] mk_hi(input logic [31:0] a, input logic [2:0] sz,
                                        input logic v, input logic le);
    return (a & ~32'h3FF) | (32'(sz) << 7) | (32'(v) << 6) | (32'(le) << 5);
  endfunction

  // expected upper-word readback from what was written
  function automatic logic [31:0] exp_hi(input logic [31:0] d);
    return (d & keep_mask(d[9:7])) | (d & 32'h3E0);
  endfunction

  task automatic wr_word(input logic hi, input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_hi = hi; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_word(input logic hi, input logic [5:0] idx, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_hi = hi; rd_idx = idx;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic lookup(input logic [31:0] a, output logic h, output logic [5:0] i);
    @(negedge clk);
    srch_en = 1; srch_addr = a;
    @(negedge clk);
    srch_en = 0;
    h = srch_hit; i = srch_idx;
  endtask

  task automatic set_pid(input logic [7:0] p);
    @(negedge clk);
    pid_wr = 1; pid_in = p;
    @(negedge clk);
    pid_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    flush_ack = 1;
    @(negedge clk);
    flush_ack = 0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a, input logic [5:0] idx);
    logic h; logic [5:0] i;
    lookup(a, h, i);
    chk(req, {31'd0, h}, 32'd1);
    chk(req, {26'd0, i}, {26'd0, idx});
  endtask

  task automatic expect_miss(input string req, input logic [31:0] a);
    logic h; logic [5:0] i;
    lookup(a, h, i);
    chk(req, {31'd0, h}, 32'd0);
    chk(req, {26'd0, i}, 32'd63);
  endtask

  task automatic t_reset();
    chk("R1 hit", {31'd0, srch_hit}, 32'd0);
    chk("R1 idx", {26'd0, srch_idx}, 32'd63);
    chk("R1 pid", {24'd0, pid}, 32'd0);
    chk("R1 flush", {31'd0, flush}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    expect_miss("R1 empty search", 32'h0000_0000);
  endtask

  task automatic t_words();
    logic [31:0] d, w;
    d = 32'h1234_5CE0;                      // 4 KB, valid, little-endian
    wr_word(1, 6'd5, d);
    rd_word(1, 6'd5, w);
    chk("R2 hi 4KB readback", w, exp_hi(d));
    chk("R2 hi literal", w, 32'h1234_50E0);
    d = mk_hi(32'h0001_7C00, 3'd2, 1, 0);   // 16 KB
    wr_word(1, 6'd6, d);
    rd_word(1, 6'd6, w);
    chk("R2 hi 16KB readback", w, 32'h0001_4140);
    wr_word(0, 6'd5, 32'hABCD_E3A5);
    rd_word(0, 6'd5, w);
    chk("R3 lo readback", w, 32'hABCD_E3A5);
    wr_word(0, 6'd6, 32'h0000_0200);
    rd_word(0, 6'd6, w);
    chk("R3 lo exec only", w, 32'h0000_0200);
    repeat (3) @(negedge clk);
    chk("R4 read held", rd_data, 32'h0000_0200);
  endtask

  task automatic t_pid_load();
    logic [31:0] w;
    set_pid(8'h2A);
    wr_word(1, 6'd9, mk_hi(32'h4000_0000, 3'd1, 1, 0));
    set_pid(8'h11);
    ack();
    chk("R9 ack cleared", {31'd0, flush}, 32'd0);
    rd_word(1, 6'd9, w);
    chk("R5 read loads pid", {24'd0, pid}, 32'h2A);
    chk("R9 load change flags", {31'd0, flush}, 32'd1);
    ack();
  endtask

  task automatic t_match();
    // current pid 0x2A; entry 9 tagged 0x2A
    expect_hit("R6 own pid", 32'h4000_0ABC, 6'd9);
    set_pid(8'h11);
    expect_miss("R6 other pid", 32'h4000_0ABC);
    set_pid(8'h00);
    wr_word(1, 6'd12, mk_hi(32'h5000_0000, 3'd1, 1, 0));
    set_pid(8'h11);
    expect_hit("R6 global entry", 32'h5000_0123, 6'd12);
    expect_miss("R6 outside page", 32'h5000_1000);
    wr_word(1, 6'd13, mk_hi(32'h6000_0000, 3'd1, 0, 0));
    expect_miss("R6 invalid entry", 32'h6000_0000);
  endtask

  task automatic t_prio();
    logic h; logic [5:0] i;
    wr_word(1, 6'd40, mk_hi(32'h7000_0000, 3'd7, 1, 0));
    wr_word(1, 6'd20, mk_hi(32'h7010_0000, 3'd1, 1, 0));
    expect_hit("R7 lowest of two", 32'h7010_0010, 6'd20);
    expect_hit("R7 single large", 32'h7020_0000, 6'd40);
    expect_hit("R11 16MB top", 32'h70FF_FFFF, 6'd40);
    expect_miss("R11 16MB past end", 32'h7100_0000);
    wr_word(1, 6'd63, mk_hi(32'h8000_0000, 3'd0, 1, 0));
    expect_hit("R11 entry 63 1KB", 32'h8000_03FF, 6'd63);
    expect_hit("R8 hit then held", 32'h8000_0000, 6'd63);
    repeat (4) @(negedge clk);
    chk("R8 held hit", {31'd0, srch_hit}, 32'd1);
    expect_miss("R11 1KB past end", 32'h8000_0400);
    repeat (4) @(negedge clk);
    h = srch_hit; i = srch_idx;
    chk("R8 held miss", {31'd0, h}, 32'd0);
    chk("R8 held idx", {26'd0, i}, 32'd63);
  endtask

  task automatic t_flush();
    ack();
    set_pid(8'h11);
    chk("R9 same value no flag", {31'd0, flush}, 32'd0);
    set_pid(8'h33);
    chk("R9 new value flags", {31'd0, flush}, 32'd1);
    ack();
    chk("R9 ack clears", {31'd0, flush}, 32'd0);
    @(negedge clk);
    pid_wr = 1; pid_in = 8'h11; flush_ack = 1;
    @(negedge clk);
    pid_wr = 0; flush_ack = 0;
    chk("R9 change beats ack", {31'd0, flush}, 32'd1);
    ack();
  endtask

  task automatic t_inv();
    logic [31:0] w;
    expect_hit("R10 before inv", 32'h5000_0123, 6'd12);
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    expect_miss("R10 global gone", 32'h5000_0123);
    expect_miss("R10 large gone", 32'h7020_0000);
    rd_word(1, 6'd12, w);
    chk("R10 fields kept", w, 32'h5000_0080);
    rd_word(0, 6'd5, w);
    chk("R10 lo kept", w, 32'hABCD_E3A5);
    set_pid(8'h11);
    wr_word(1, 6'd12, mk_hi(32'h5000_0000, 3'd1, 1, 0));
    expect_hit("R10 rewrite", 32'h5000_0FFF, 6'd12);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_words();
    t_pid_load();
    t_match();
    t_prio();
    t_flush();
    t_inv();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule